// File: doc/BRIEF.md
# Cascaded Preset Low-Frequency Square-Wave Generator

This block turns a fixed-rate input clock into a very slow reference square wave. There are ten preset rates, from 0.01 Hz to 100 Hz. A single 16-bit counter cannot span the largest division, so two 16-bit counters run in series. The first is a prescaler. Its wrap pulse is captured in a flop, and that flop steps the second counter. Each time the second counter wraps, the square-wave output flips and a one-cycle tick is produced. The output therefore has a 50% duty cycle.

A 4-bit code selects the preset. A new code is adopted only when the current half-period ends, so a change never cuts a half-period short. An enable input freezes the whole chain without losing its position.

Top module: `lfgen_top`

## Requirements
- R1: While `rst_ni` is low, `sq_o` and `tick_o` are 0, both counters are cleared, and the active preset is code 9 (100 Hz).
- R2: Code n on `sel_i` selects one rate: 0 → 0.01 Hz, 1 → 0.1 Hz, 2 → 0.2 Hz, 3 → 0.5 Hz, 4 → 1 Hz, 5 → 2 Hz, 6 → 5 Hz, 7 → 10 Hz, 8 → 50 Hz, 9 → 100 Hz. The half-period of a preset is CLK_HZ·50 / (rate in centihertz) input cycles. With the default CLK_HZ = 24000 this runs from 1,200,000 cycles (code 0) down to 120 cycles (code 9).
- R3: The division is split over two 16-bit counters. The prescaler counts CLK_HZ/200 cycles, and the period counter counts the remaining factor. The prescaler's wrap pulse is registered before it steps the period counter. As a result, the first tick after reset comes on the (half+1)-th enabled clock edge, and each later tick comes exactly half enabled cycles after the one before.
- R4: `tick_o` is high for exactly one clock cycle per half-period.
- R5: `sq_o` changes value in the same cycle in which `tick_o` goes high, and at no other time. This gives a 50% duty cycle.
- R6: A new valid code on `sel_i` does not alter the half-period in progress. It is adopted at the next tick and sets the length of every half-period after that tick.
- R7: Codes 10 to 15 on `sel_i` are ignored, and the last adopted preset stays active.
- R8: While `en_i` is low, the counters and `sq_o` hold their values and `tick_o` stays 0. A half-period measured in enabled cycles is unchanged by a pause.
- R9: No half-period is shorter than that of the fastest preset, which is CLK_HZ/200 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input timebase clock (CLK_HZ) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; low freezes the chain |
| sel_i | input | 4 | Preset code, 0 to 9 valid |
| sq_o | output | 1 | 50% duty square wave |
| tick_o | output | 1 | One-cycle pulse at each half-period boundary |

## Verification
A wrong count limit, a missing pulse register or a counter that fails to clear shows up as a wrong spacing between ticks. It becomes visible at the very first tick after reset or after a preset change, within one half-period. An early adoption of a new code shows up in the half-period that was already in progress rather than the one after it. A bad flip of `sq_o`, or a tick that lasts more than one cycle, is visible in the cycle it happens. A pause that leaks is visible as a tick, or an edge on `sq_o`, while the enable is low.

// File: rtl/lfgen_pkg.sv
package lfgen_pkg;
  localparam int unsigned NUM_PRESETS = 10;
  localparam int unsigned SEL_W       = 4;
  localparam int unsigned STAGE_W     = 16;
  localparam int unsigned NUM_STAGES  = 2;

  typedef logic [SEL_W-1:0]   sel_t;
  typedef logic [STAGE_W-1:0] cnt_t;

  // preset rate in centihertz
  function automatic int unsigned preset_centi_hz(input int unsigned idx);
    case (idx)
      0:       return 1;
      1:       return 10;
      2:       return 20;
      3:       return 50;
      4:       return 100;
      5:       return 200;
      6:       return 500;
      7:       return 1000;
      8:       return 5000;
      default: return 10000;
    endcase
  endfunction

  function automatic int unsigned half_cycles(input int unsigned clk_hz, input int unsigned idx);
    return (clk_hz * 50) / preset_centi_hz(idx);
  endfunction
endpackage

// File: rtl/lfgen_preset_rom.sv
module lfgen_preset_rom
  import lfgen_pkg::*;
#(
  parameter int unsigned CLK_HZ = 24000
) (
  input  sel_t idx_i,
  output cnt_t pre_lim_o,
  output cnt_t per_lim_o
);
  localparam int unsigned PRE_CNT = CLK_HZ / 200;

  cnt_t pre_tab [NUM_PRESETS];
  cnt_t per_tab [NUM_PRESETS];

  for (genvar g = 0; g < NUM_PRESETS; g++) begin : g_tab
    assign pre_tab[g] = cnt_t'(PRE_CNT - 1);
    assign per_tab[g] = cnt_t'(half_cycles(CLK_HZ, g) / PRE_CNT - 1);
  end

  always_comb begin
    pre_lim_o = pre_tab[NUM_PRESETS-1];
    per_lim_o = per_tab[NUM_PRESETS-1];
    for (int i = 0; i < NUM_PRESETS; i++) begin
      if (idx_i == sel_t'(i)) begin
        pre_lim_o = pre_tab[i];
        per_lim_o = per_tab[i];
      end
    end
  end
endmodule

// File: rtl/lfgen_stage.sv
module lfgen_stage
  import lfgen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic step_i,
  input  cnt_t lim_i,
  output logic wrap_o
);
  cnt_t cnt_q;

  // >= so a shrinking limit never strands the counter
  assign wrap_o = step_i && (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (en_i && step_i)   cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/lfgen_top.sv
module lfgen_top
  import lfgen_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 24000,
  parameter int unsigned RST_PRESET = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sq_o,
  output logic             tick_o
);
  localparam int unsigned LAST = NUM_STAGES - 1;
  localparam sel_t        LAST_VALID = sel_t'(NUM_PRESETS - 1);

  sel_t act_q;
  cnt_t pre_lim, per_lim;
  cnt_t lim  [NUM_STAGES];
  logic step [NUM_STAGES];
  logic wrap [NUM_STAGES];
  logic tc_q [NUM_STAGES];
  logic sq_q;
  logic half_done;

  lfgen_preset_rom #(.CLK_HZ(CLK_HZ)) u_rom (
    .idx_i     (act_q),
    .pre_lim_o (pre_lim),
    .per_lim_o (per_lim)
  );

  assign lim[0]    = pre_lim;
  assign lim[LAST] = per_lim;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign step[g] = 1'b1;
    end else begin : g_next
      assign step[g] = tc_q[g-1];
    end

    lfgen_stage u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .step_i (step[g]),
      .lim_i  (lim[g]),
      .wrap_o (wrap[g])
    );

    if (g == LAST) begin : g_tick
      // final pulse never lingers through a pause
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tc_q[g] <= 1'b0;
        else         tc_q[g] <= en_i && wrap[g];
      end
    end else begin : g_link
      // registered hand-off; held while paused so no step is lost
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   tc_q[g] <= 1'b0;
        else if (en_i) tc_q[g] <= wrap[g];
      end
    end
  end

  assign half_done = en_i && wrap[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q  <= 1'b0;
      act_q <= sel_t'(RST_PRESET);
    end else if (half_done) begin
      sq_q <= ~sq_q;
      if (sel_i <= LAST_VALID) act_q <= sel_i;
    end
  end

  assign sq_o   = sq_q;
  assign tick_o = tc_q[LAST];
endmodule

// File: rtl/lfgen_checker.sv
module lfgen_checker #(
  parameter int unsigned CLK_HZ = 24000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tick_o,
  input logic sq_o
);
  localparam int unsigned MIN_GAP = CLK_HZ / 200;

  logic [31:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= '0;
    else if (tick_o) gap_q <= {31'd0, en_i};
    else             gap_q <= gap_q + {31'd0, en_i};
  end

  AST_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> gap_q >= MIN_GAP); // R9
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R4
  AST_SQ_FLIP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> sq_o != $past(sq_o)); // R5
  AST_SQ_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |-> $stable(sq_o)); // R5
  AST_PAUSE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && $stable(sq_o))); // R8
endmodule

bind lfgen_top lfgen_checker #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .tick_o (tick_o),
  .sq_o   (sq_o)
);

// File: tb/lfgen_top_test.sv
module lfgen_top_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CLK_HZ = 800;

  typedef struct {
    int unsigned len;
    string       tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] sel = 4'd9;
  logic       sq, tick;

  exp_t        q[$];
  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          exp_sq = 1'b0;
  int          last_valid = 9;
  bit          done = 1'b0;

  lfgen_top #(.CLK_HZ(CLK_HZ)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .en_i   (en),
    .sel_i  (sel),
    .sq_o   (sq),
    .tick_o (tick)
  );

  always #2.5 clk = ~clk;

  function automatic int unsigned half_of(input int s);
    int unsigned c;
    case (s)
      0: c = 1;      1: c = 10;    2: c = 20;   3: c = 50;   4: c = 100;
      5: c = 200;    6: c = 500;   7: c = 1000; 8: c = 5000; default: c = 10000;
    endcase
    return (CLK_HZ * 50) / c;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // enabled edges since last tick
  always @(posedge clk) if (rst_n && en) cyc++;

  // monitor: pop one expected half-period per tick
  always @(negedge clk) begin
    if (rst_n && tick) begin
      if (q.size() == 0) begin
        check(1'b0, "R6", "unexpected tick", cyc, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.len, e.tag, "half-period", cyc, e.len);
        check(cyc >= CLK_HZ / 200, "R9", "min half-period", cyc, CLK_HZ / 200);
        exp_sq = ~exp_sq;
        check(sq == exp_sq, "R5", "sq on tick", sq, exp_sq);
      end
      cyc = 0;
    end
  end

  // driver: change code while exactly one half-period is in flight
  task automatic run(input int s, input int n, input string tag);
    do begin
      @(negedge clk);
      #1;
    end while (q.size() != 1);
    sel = 4'(s);
    if (s <= 9) last_valid = s;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.len = half_of(last_valid);
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic pause(input int len);
    bit held_sq;
    bit leak;
    do begin
      @(negedge clk);
      #1;
    end while (q.size() != 1);
    held_sq = sq;
    leak = 1'b0;
    en = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tick || sq != held_sq) leak = 1'b1;
    end
    check(!leak, "R8", "pause leaked", leak, 0);
    #1 en = 1'b1;
  endtask

  initial begin
    exp_t e0;
    repeat (3) @(negedge clk);
    check(sq == 1'b0, "R1", "sq in reset", sq, 0);
    check(tick == 1'b0, "R1", "tick in reset", tick, 0);
    #1;
    en = 1'b1;
    rst_n = 1'b1;
    e0.len = half_of(9) + 1;
    e0.tag = "R3";
    q.push_back(e0);
    run(9, 2, "R4");
    run(8, 2, "R2");
    run(7, 2, "R6");
    run(12, 2, "R7");
    pause(25);
    run(6, 1, "R2");
    run(5, 1, "R2");
    run(4, 1, "R2");
    run(3, 1, "R3");
    run(2, 1, "R2");
    run(1, 1, "R2");
    run(0, 1, "R2");
    run(15, 1, "R7");
    run(9, 2, "R6");
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R4", "tick after pulse", tick, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", q.size(), 0);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule